// File: doc/BRIEF.md
# Change-of-state input interrupt controller

This peripheral watches forty-eight digital input lines, organised as six groups of eight. It brings them into the clock domain through a two-flop synchronizer and presents them to a host through an eight-byte register window with a byte-wide data path. The host reads the input levels one group at a time. A change in either direction on any line marks its group as changed, but only if that group is armed.

A single control and status byte sits at offset 7. A write to it arms or disarms each group. A read of it returns the groups that have changed and an active-low "this device is interrupting" bit. The host can therefore share one interrupt wire with other devices and poll that bit to find out whether this block raised the request. A status read also acknowledges the request: it clears every latched group flag at the clock edge that ends the read.

The data bytes sit at offsets 0, 1 and 2 for groups 0 to 2, and at offsets 4, 5 and 6 for groups 3 to 5. Offset 3 is an unused hole.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, every group is disarmed, no group flag is set, the synchronizer and history flops hold 0, and a read of offset 7 returns 0x40.
- R2: A read of offset 0, 1 or 2 returns group 0, 1 or 2, and a read of offset 4, 5 or 6 returns group 3, 4 or 5. Bit n of that byte is input 8·g+n. A level change becomes visible there after two rising clock edges.
- R3: A rising or a falling transition on any input of an armed group sets that group's flag. The flag, and `irq`, go high at the third rising edge after the input changes.
- R4: A read of offset 7 returns the group flags in bits 5..0 (bit g for group g), the inverse of `irq` in bit 6, and 0 in bit 7.
- R5: A read of offset 7 that is present at a rising edge clears all group flags at that edge. A change detected at that same edge in an armed group is kept and sets its flag.
- R6: `irq` is high exactly when at least one group flag is set. A flag is never set for a group that is not armed.
- R7: A transition in a group that is not armed leaves that group's flag at 0, so it neither raises `irq` nor appears in the status byte.
- R8: A read of offset 3 returns 0x00. While `bus_rd` is low, `bus_rdata` is 0x00.
- R9: A write to offset 7 loads the arm mask from bits 5..0, where bit g arms group g, and clears the flags of every group it disarms. Writing 0 therefore drops `irq` at that edge, and a following status read returns 0x40.
- R10: Writes to offsets 0 to 6 change neither the input bytes read back, the arm mask, the flags nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_lines | input | 48 | Asynchronous input lines; bit 8·g+n is bit n of group g |
| bus_addr | input | 3 | Byte offset within the register window |
| bus_rd | input | 1 | Read strobe; a status read takes effect at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address; 0 when not reading |
| irq | output | 1 | Active-high interrupt request |

## Verification
The assertions take it for granted that `bus_rd` and `bus_wr` are never high together, and that the bus signals are steady around each rising edge. The bench changes the address, the strobes and the input lines only on falling edges, and its random phase picks at most one strobe per cycle. The input lines are treated as asynchronous, but the bench changes them on falling edges so that the reference model knows exactly which edge samples each change. Because of this, the model can predict the two-edge read-back delay and the three-edge flag delay exactly.

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int GROUPS = 6,
  parameter int GW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GROUPS*GW-1:0] in_lines,
  input  logic [2:0]           bus_addr,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 irq
);
  localparam int NIN = GROUPS * GW;
  localparam logic [2:0] CSR_ADDR = 3'd7;
  localparam logic [2:0] HOLE_ADDR = 3'd3;

  logic [NIN-1:0]    sync1, sync2, prev;
  logic [GROUPS-1:0] en, flag, chg;

  wire csr_rd = bus_rd && (bus_addr == CSR_ADDR);
  wire csr_wr = bus_wr && (bus_addr == CSR_ADDR);
  wire unused_wdata = ^bus_wdata[7:GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_chg
    assign chg[g] = |(sync2[g*GW +: GW] ^ prev[g*GW +: GW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= in_lines;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
    end else begin
      flag <= ((csr_rd ? '0 : flag) | (chg & en)) &
              (csr_wr ? bus_wdata[GROUPS-1:0] : {GROUPS{1'b1}});
      if (csr_wr) en <= bus_wdata[GROUPS-1:0];
    end
  end

  assign irq = |flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == CSR_ADDR)
        bus_rdata = {1'b0, ~irq, flag};
      else if (bus_addr < HOLE_ADDR)
        bus_rdata = sync2[32'(bus_addr) * GW +: GW];
      else if (bus_addr > HOLE_ADDR)
        bus_rdata = sync2[(32'(bus_addr) - 1) * GW +: GW];
    end
  end
endmodule

module cos_irq_ctrl_chk #(
  parameter int GROUPS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic [GROUPS-1:0] flag,
  input logic [GROUPS-1:0] en,
  input logic [GROUPS-1:0] chg
);
  assert_status_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd7) |-> (bus_rdata[6] == !irq && !bus_rdata[7]));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd7) |=> ((flag & ~$past(chg & en)) == '0));

  assert_flags_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~en) == '0));

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~$past(flag) & ~$past(chg & en)) == '0));

  assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || bus_addr == 3'd3) |-> (bus_rdata == 8'h00));

  assert_disarm_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd7 && bus_wdata[GROUPS-1:0] == '0) |=> !irq);
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .flag(flag), .en(en), .chg(chg)
);

// File: tb/cos_irq_ctrl_bench.sv
`timescale 1ns/100ps
module cos_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] in_lines = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cos_irq_ctrl u_cos_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .in_lines(in_lines), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference: history of sampled input words, newest first
  logic [47:0] hq[$] = '{48'h0, 48'h0, 48'h0};
  logic [5:0]  m_flag = '0, m_en = '0;

  always @(posedge clk) begin
    logic [5:0] seen;
    logic [5:0] nf;
    if (!rst_n) begin
      hq = '{48'h0, 48'h0, 48'h0};
      m_flag = '0;
      m_en = '0;
    end else begin
      for (int g = 0; g < 6; g++) seen[g] = ((hq[1] ^ hq[2]) >> (8*g)) & 48'hFF ? 1'b1 : 1'b0;
      nf = ((bus_rd && bus_addr == 3'd7) ? 6'h0 : m_flag) | (seen & m_en);
      if (bus_wr && bus_addr == 3'd7) begin
        nf = nf & bus_wdata[5:0];
        m_en = bus_wdata[5:0];
      end
      m_flag = nf;
      hq.push_front(in_lines);
      void'(hq.pop_back());
    end
  end

  function automatic logic [7:0] exp_rdata();
    int grp;
    if (!bus_rd || bus_addr == 3'd3) return 8'h00;
    if (bus_addr == 3'd7) return {1'b0, (m_flag == 0), m_flag};
    grp = (bus_addr < 3) ? int'(bus_addr) : int'(bus_addr) - 1;
    return 8'((hq[1] >> (8*grp)) & 48'hFF);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R6", int'(irq), int'(m_flag != 0));
      if (!bus_rd || bus_addr == 3'd3) chk("R8", bus_rdata, exp_rdata());
      else if (bus_addr == 3'd7) chk("R4", bus_rdata, exp_rdata());
      else chk("R2", bus_rdata, exp_rdata());
    end
  end

  task automatic cyc(bit rd, bit wr, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    cyc(0, 0, 3'd0, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 3'd7, 8'h00); #1;
    chk("R1", bus_rdata, 8'h40);
    chk("R1", int'(irq), 0);

    // R2: byte mapping and two-edge visibility
    idle(); in_lines = 48'hA1B2C3D4E5F6;
    idle();
    cyc(1, 0, 3'd0, 0); #1; chk("R2", bus_rdata, 8'hF6);
    cyc(1, 0, 3'd1, 0); #1; chk("R2", bus_rdata, 8'hE5);
    cyc(1, 0, 3'd2, 0); #1; chk("R2", bus_rdata, 8'hD4);
    cyc(1, 0, 3'd4, 0); #1; chk("R2", bus_rdata, 8'hC3);
    cyc(1, 0, 3'd5, 0); #1; chk("R2", bus_rdata, 8'hB2);
    cyc(1, 0, 3'd6, 0); #1; chk("R2", bus_rdata, 8'hA1);
    chk("R7", int'(irq), 0);
    idle(); in_lines = '0;
    repeat (4) idle();

    // R3: rising edge in armed group 1
    cyc(0, 1, 3'd7, 8'h3F);
    idle(); in_lines[9] = 1'b1;
    idle(); #1; chk("R3", int'(irq), 0);
    idle(); #1; chk("R3", int'(irq), 0);
    idle(); #1; chk("R3", int'(irq), 1);
    cyc(1, 0, 3'd7, 0); #1; chk("R4", bus_rdata, 8'h02);
    idle(); #1; chk("R5", int'(irq), 0);
    // R3: falling edge
    in_lines[9] = 1'b0;
    idle(); idle();
    idle(); #1; chk("R3", int'(irq), 1);
    cyc(1, 0, 3'd7, 0);
    idle(); #1; chk("R5", int'(irq), 0);

    // R7: disarm group 2, toggle it
    cyc(0, 1, 3'd7, 8'h3B);
    idle(); in_lines[16] = 1'b1;
    repeat (4) idle();
    #1; chk("R7", int'(irq), 0);
    cyc(1, 0, 3'd7, 0); #1; chk("R7", bus_rdata, 8'h40);

    // R10: write to data offset ignored
    cyc(0, 1, 3'd2, 8'hFF);
    cyc(0, 1, 3'd5, 8'h00);
    cyc(1, 0, 3'd2, 0); #1; chk("R10", bus_rdata, 8'h01);
    chk("R10", int'(irq), 0);

    // R8: hole and idle read data
    cyc(1, 0, 3'd3, 0); #1; chk("R8", bus_rdata, 8'h00);
    idle(); #1; chk("R8", bus_rdata, 8'h00);

    // R5: change detected at the clearing edge is kept
    idle(); in_lines[0] = 1'b1;
    idle();
    cyc(1, 0, 3'd7, 0); #1; chk("R5", bus_rdata, 8'h40);
    idle(); #1; chk("R5", int'(irq), 1);

    // R9: write 0 drops irq, following read shows nothing pending
    cyc(0, 1, 3'd7, 8'h00);
    idle(); #1; chk("R9", int'(irq), 0);
    cyc(1, 0, 3'd7, 0); #1; chk("R9", bus_rdata, 8'h40);

    // random phase, checked by the per-cycle model compare
    cyc(0, 1, 3'd7, 8'h3F);
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      cyc(op == 0 || op == 1 || op == 2, op == 3,
          (op == 0) ? 3'd7 : 3'($urandom_range(0, 7)), 8'($urandom));
      if ($urandom_range(0, 2) == 0)
        in_lines = in_lines ^ (48'h1 << $urandom_range(0, 47));
    end

    idle(); idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule